// File: doc/BRIEF.md
# Selectable Clock Output Generator

This block drives one clock output pin from a 3-bit select field held in a small register. The field chooses among the crystal oscillator clock passed through unchanged, that clock divided by 2, 4, 8, 16 or 32, a separate RC oscillator clock, or no output at all. When the RC clock is chosen, the block raises a request so that the RC oscillator is switched on.

Software loads the field through a simple write port clocked by the oscillator clock. Bits 2 to 0 of the written byte hold the field and the upper bits are ignored. The register reads back with its upper bits at zero, and it resets to the off code.

Every change of selection passes through an idle low state. The running source is gated off only while it is low. The new source is gated on only while it is low. Crossings into and out of the RC clock domain use a request/acknowledge handshake, so the two sources are never gated onto the pin together.

Top module: `clkout_gen`

## Requirements
- R1: After reset the select field reads 111 (`rd_data` = 0x07), `rc_en_req` is low and `clk_out` stays low.
- R2: With select code 000, `clk_out` follows the oscillator clock: one rising edge per oscillator cycle, high in the first half of the cycle and low in the second half.
- R3: With select code k from 001 to 101, `clk_out` is the oscillator clock divided by 2^k with a 50% duty cycle. The divider is a free-running counter that advances by one on every oscillator rising edge.
- R4: With select code 110, `clk_out` equals the RC clock. The RC path is requested only after the select field has held 110.
- R5: `rc_en_req` is high exactly while the select field holds 110.
- R6: With select code 111, `clk_out` is held at a static low level.
- R7: A write with `wr_en` high loads `wr_data[2:0]` into the select field. `wr_data[7:3]` has no effect. While `wr_en` is low, the field is unchanged. `rd_data` returns the field in bits 2 to 0 with zeros above.
- R8: Every switch between any two codes is glitch-free: no high or low pulse on `clk_out` is shorter than half an oscillator period. The oscillator path and the RC path are never gated on at the same time. The oscillator gate changes only while both the old and the new source are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Crystal oscillator clock; clocks the register, divider and switch control |
| rc_clk | input | 1 | RC oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the select register |
| wr_data | input | 8 | Write data; bits 2 to 0 carry the select code |
| rd_data | output | 8 | Read-back of the select register |
| clk_out | output | 1 | Selected clock output |
| rc_en_req | output | 1 | Request to enable the RC oscillator |

## Verification
A wrong divider count or a wrong gated code changes the number of rising edges on `clk_out`, or the share of high samples, in the next 128-cycle window of the oscillator. A handshake that is stuck leaves the pin low, or it leaves the previous source running, once the settle time after a write has passed. A gate that switches at the wrong moment shows up at once as a pulse narrower than half an oscillator period. All 64 ordered pairs of codes are swept, so every path into and out of the idle state is covered.

// File: rtl/clkout_pkg.sv
`timescale 1ns/100ps
package clkout_pkg;
  localparam int SEL_W      = 3;
  localparam int DIV_STAGES = 5;

  typedef logic [SEL_W-1:0] sel_t;

  localparam sel_t CODE_PASS = 3'b000;
  localparam sel_t CODE_RC   = 3'b110;
  localparam sel_t CODE_OFF  = 3'b111;

  // Level an oscillator-derived source has, judged at a falling edge of the
  // oscillator clock: the pass-through clock is low there, a divided clock is
  // its counter tap, and non-oscillator codes contribute nothing.
  function automatic logic src_level(input sel_t code,
                                     input logic [DIV_STAGES-1:0] cnt);
    if (code >= 3'd1 && code <= 3'(DIV_STAGES))
      return cnt[code - 3'd1];
    return 1'b0;
  endfunction
endpackage

// File: rtl/clkout_sync.sv
`timescale 1ns/100ps
module clkout_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clkout_divider.sv
`timescale 1ns/100ps
module clkout_divider #(
  parameter int CNT_W = clkout_pkg::DIV_STAGES
) (
  input  logic             osc_clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge osc_clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  // R3
  div_step_chk: assert property (@(posedge osc_clk) disable iff (rst)
    !$past(rst) |-> cnt == CNT_W'($past(cnt) + 1'b1));
endmodule

// File: rtl/clkout_osc_ctrl.sv
`timescale 1ns/100ps
module clkout_osc_ctrl import clkout_pkg::*; (
  input  logic                  osc_clk,
  input  logic                  rst,
  input  sel_t                  tgt_sel,
  input  logic [DIV_STAGES-1:0] cnt,
  input  logic                  rc_ack,
  output logic                  rc_want,
  output sel_t                  act_sel
);
  // Decisions happen on the falling edge, where the pass-through clock is low
  // and every counter tap is stable.
  always_ff @(negedge osc_clk) begin
    if (rst) begin
      act_sel <= CODE_OFF;
      rc_want <= 1'b0;
    end else if (act_sel != CODE_OFF) begin
      if (act_sel != tgt_sel && !src_level(act_sel, cnt))
        act_sel <= CODE_OFF;
    end else if (rc_ack == rc_want) begin
      if (tgt_sel == CODE_RC)
        rc_want <= 1'b1;
      else if (rc_want)
        rc_want <= 1'b0;
      else if (tgt_sel != CODE_OFF && !src_level(tgt_sel, cnt))
        act_sel <= tgt_sel;
    end
  end

  // R8
  switch_low_chk: assert property (@(negedge osc_clk) disable iff (rst)
    (!$past(rst) && act_sel != $past(act_sel)) |->
      (!src_level($past(act_sel), $past(cnt)) && !src_level(act_sel, $past(cnt))));

  // R4
  rc_req_chk: assert property (@(negedge osc_clk) disable iff (rst)
    $rose(rc_want) |-> $past(tgt_sel) == CODE_RC);
endmodule

// File: rtl/clkout_rc_gate.sv
`timescale 1ns/100ps
module clkout_rc_gate (
  input  logic rc_clk,
  input  logic rst_rc,
  input  logic want_rc,
  output logic rc_gate
);
  // Gate changes on the RC falling edge, while the RC clock is low.
  always_ff @(negedge rc_clk) begin
    if (rst_rc) rc_gate <= 1'b0;
    else        rc_gate <= want_rc;
  end
endmodule

// File: rtl/clkout_gen.sv
`timescale 1ns/100ps
module clkout_gen import clkout_pkg::*; #(
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             osc_clk,
  input  logic             rc_clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             clk_out,
  output logic             rc_en_req
);
  sel_t                  sel_q;
  sel_t                  act_sel;
  logic [DIV_STAGES-1:0] cnt;
  logic                  rc_want, want_rc, rst_rc, rc_gate, rc_ack;
  logic                  osc_src;
  logic                  unused_hi;

  always_ff @(posedge osc_clk) begin
    if (rst)        sel_q <= CODE_OFF;
    else if (wr_en) sel_q <= wr_data[SEL_W-1:0];
  end

  assign unused_hi = ^wr_data[REG_W-1:SEL_W];
  assign rd_data   = {{(REG_W-SEL_W){1'b0}}, sel_q};
  assign rc_en_req = (sel_q == CODE_RC);

  clkout_divider #(.CNT_W(DIV_STAGES)) u_div (
    .osc_clk (osc_clk),
    .rst     (rst),
    .cnt     (cnt)
  );

  clkout_osc_ctrl u_ctrl (
    .osc_clk (osc_clk),
    .rst     (rst),
    .tgt_sel (sel_q),
    .cnt     (cnt),
    .rc_ack  (rc_ack),
    .rc_want (rc_want),
    .act_sel (act_sel)
  );

  clkout_sync #(.STAGES(SYNC_STAGES)) u_want_sync (
    .clk (rc_clk), .d (rc_want), .q (want_rc)
  );

  clkout_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk (rc_clk), .d (rst), .q (rst_rc)
  );

  clkout_rc_gate u_rcgate (
    .rc_clk  (rc_clk),
    .rst_rc  (rst_rc),
    .want_rc (want_rc),
    .rc_gate (rc_gate)
  );

  clkout_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk (osc_clk), .d (rc_gate), .q (rc_ack)
  );

  always_comb begin
    if (act_sel == CODE_PASS) osc_src = osc_clk;
    else                      osc_src = src_level(act_sel, cnt);
  end

  assign clk_out = osc_src | (rc_gate & rc_clk);

  // R8
  no_overlap_chk: assert property (@(posedge osc_clk) disable iff (rst)
    !(act_sel != CODE_OFF && rc_gate));
endmodule

// File: tb/test_clkout_gen.sv
`timescale 1ns/100ps
module test_clkout_gen;
  logic       osc_clk = 1'b0;
  logic       rc_clk  = 1'b0;
  logic       rst     = 1'b1;
  logic       wr_en   = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       clk_out;
  logic       rc_en_req;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;
  bit  mon_en = 1'b0;
  int  edge_cnt = 0;
  int  glitches = 0;
  realtime last_change = 0.0;
  int  m_edges, m_highs, m_mism;

  clkout_gen i_clkout_gen (
    .osc_clk   (osc_clk),
    .rc_clk    (rc_clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .clk_out   (clk_out),
    .rc_en_req (rc_en_req)
  );

  always #2 osc_clk = ~osc_clk;
  initial begin
    #6.5;
    forever begin
      rc_clk = ~rc_clk;
      #8;
    end
  end

  always @(posedge clk_out) if (mon_en) edge_cnt++;

  always @(clk_out) begin
    if (mon_en) begin
      if ($realtime - last_change < 1.5) glitches++;
      last_change = $realtime;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_sel(input logic [7:0] d);
    @(posedge osc_clk); #1;
    wr_en = 1'b1; wr_data = d;
    @(posedge osc_clk); #1;
    wr_en = 1'b0; wr_data = ~d;
  endtask

  task automatic settle();
    repeat (150) @(posedge osc_clk);
  endtask

  task automatic measure();
    @(posedge osc_clk); #1;
    edge_cnt = 0; m_highs = 0; m_mism = 0;
    for (int i = 0; i < 128; i++) begin
      if (clk_out === 1'b1) m_highs++;
      if (clk_out !== rc_clk) m_mism++;
      @(negedge osc_clk); #1;
      if (clk_out === 1'b1) m_highs++;
      if (clk_out !== rc_clk) m_mism++;
      @(posedge osc_clk); #1;
    end
    m_edges = edge_cnt;
  endtask

  task automatic verify_code(input int c);
    measure();
    if (c == 0) begin
      check(m_edges == 128, "R2", "pass edges", m_edges, 128);
      check(m_highs == 128, "R2", "pass high samples", m_highs, 128);
    end else if (c <= 5) begin
      check(m_edges == (128 >> c), "R3", "divided edges", m_edges, 128 >> c);
      check(m_highs == 128, "R3", "divided high samples", m_highs, 128);
    end else if (c == 6) begin
      check(m_edges == 32, "R4", "rc edges", m_edges, 32);
      check(m_mism == 0, "R4", "rc mismatches", m_mism, 0);
    end else begin
      check(m_edges == 0, "R6", "off edges", m_edges, 0);
      check(m_highs == 0, "R6", "off high samples", m_highs, 0);
    end
    check(rd_data == 8'(c), "R7", "read-back", rd_data, c);
    check(rc_en_req == (c == 6), "R5", "rc request", rc_en_req, (c == 6));
  endtask

  initial begin
    repeat (30) @(posedge osc_clk);
    #1 rst = 1'b0;
    repeat (4) @(posedge osc_clk);
    #1;
    check(rd_data == 8'h07, "R1", "reset read-back", rd_data, 7);
    check(rc_en_req == 1'b0, "R1", "reset rc request", rc_en_req, 0);
    last_change = $realtime;
    mon_en = 1'b1;
    measure();
    check(m_edges == 0, "R1", "reset output edges", m_edges, 0);
    check(m_highs == 0, "R1", "reset output highs", m_highs, 0);

    for (int from = 0; from < 8; from++) begin
      for (int to = 0; to < 8; to++) begin
        write_sel({5'(from * 3 + to + 1), 3'(from)});
        settle();
        verify_code(from);
        write_sel({5'(to * 5 + from + 7), 3'(to)});
        settle();
        verify_code(to);
        check(glitches == 0, "R8", "narrow pulses", glitches, 0);
      end
    end

    // R7: data presented without the write strobe must not change anything
    write_sel(8'hF9);
    settle();
    wr_data = 8'h06;
    repeat (10) @(posedge osc_clk);
    wr_data = 8'h00;
    settle();
    verify_code(1);

    check(glitches == 0, "R8", "narrow pulses total", glitches, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge osc_clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule